// File: doc/BRIEF.md
# Memory Wait-State Generator

This block stretches processor bus cycles that target slow memory regions by holding the processor's READY input low for a fixed number of clocks. Each region has a wait count taken from a parameter table: a fast static RAM region can use zero waits, while a slow read-only region can take several. At a 4 MHz processor clock every wait state adds 250 ns to the bus cycle. On a write, that extra time also widens the write pulse, which lets a slow device meet its minimum pulse width.

A bus cycle is taken when the cycle-start pulse arrives with exactly one of the read or write strobes active. The region is the lowest-numbered asserted select line. A write aimed at a read-only region is not passed on to that device. Instead the block raises a one-clock error pulse and the cycle completes with no wait states. Per-region device write enables carry writes only to regions that accept them.

The controller has three states. `ST_IDLE` waits for a cycle start. `ST_STALL` holds READY low while a countdown runs. `ST_ERR` emits the error pulse. Its transitions are:
- `ST_IDLE` to `ST_STALL` on an accepted start to a writable or read access whose wait count is nonzero.
- `ST_IDLE` to `ST_ERR` on an accepted write to a read-only region.
- `ST_STALL` to `ST_IDLE` when the countdown is on its last wait clock.
- `ST_ERR` to `ST_IDLE` unconditionally.

Top module: `ws_ready_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied, `ready` is 1 and `ro_err` is 0, even if reset arrives in the middle of a stall.
- R2: For an accepted access whose region has a wait count n > 0 (and which is not a write to a read-only region), `ready` is 0 for exactly n consecutive clocks, starting with the clock that follows the edge that sampled `cyc_start`. After that, `ready` returns to 1.
- R3: An accepted access to a region with wait count 0 never drives `ready` low.
- R4: Region i takes its wait count from bits [i*CW +: CW] of `WAIT_TABLE`. With the default values, regions 0, 1, 2 and 3 take 0, 1, 2 and 5 waits.
- R5: When several `rgn_sel` bits are high, the lowest index wins. When no bit is high, the cycle gets no wait and no error.
- R6: `cyc_start` is ignored unless exactly one of `rd` and `wr` is 1.
- R7: A `cyc_start` that arrives while a stall or error pulse is in progress is ignored. This includes the last stall clock. Such a pulse neither extends nor restarts the wait.
- R8: An accepted write to a region whose `RO_MASK` bit is 1 drives `ro_err` high for exactly one clock, on the clock after the start edge, and leaves `ready` at 1 throughout. The default `RO_MASK` marks region 3 as read-only.
- R9: `dev_we[i]` is combinationally 1 exactly when `wr` is 1, `rd` is 0, region i wins the selection and region i is writable. A read-only region never receives a write enable.
- R10: An accepted write to a writable region with n > 0 waits n clocks, the same as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a bus cycle |
| rgn_sel | input | NREG | Region chip selects, one bit per region |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| ready | output | 1 | Processor READY; low while a wait state is inserted |
| ro_err | output | 1 | One-clock pulse on a write to a read-only region |
| dev_we | output | NREG | Per-region write enable forwarded to the devices |

## Verification
Two functions can collide in one cycle: a new cycle start can arrive on the same clock on which a running stall performs its release, or on the same clock as the error pulse. The bench provokes both by re-pulsing `cyc_start` at chosen sample points inside a stall, including its final wait clock, and during an error pulse. It judges the result by counting low `ready` clocks and `ro_err` clocks and comparing the counts with the region's table value, so a restarted or extended wait shows up as a wrong count. A full sweep over every select pattern and strobe combination covers the selection priority and the forwarding of writes.

// File: rtl/ws_pkg.sv
package ws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_ERR   = 2'd2
    } ws_state_e;

endpackage

// File: rtl/ws_region_lookup.sv
module ws_region_lookup #(
    parameter int                    NREG       = 4,
    parameter int                    CW         = 3,
    parameter logic [NREG*CW-1:0]    WAIT_TABLE = '0,
    parameter logic [NREG-1:0]       RO_MASK    = '0
) (
    input  logic [NREG-1:0] sel,
    output logic [NREG-1:0] win_oh,
    output logic            hit,
    output logic [CW-1:0]   wait_n,
    output logic            ro
);

    // blocked[i] is high when a lower-numbered select is active
    logic [NREG:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_prio
            assign win_oh[gi]      = sel[gi] & ~blocked[gi];
            assign blocked[gi + 1] = blocked[gi] | sel[gi];
        end
    endgenerate

    assign hit = blocked[NREG];

    always_comb begin
        wait_n = '0;
        ro     = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (win_oh[i]) begin
                wait_n = wait_n | WAIT_TABLE[i*CW +: CW];
                ro     = ro | RO_MASK[i];
            end
        end
    end

endmodule

// File: rtl/ws_countdown.sv
module ws_countdown #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));                            // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt > ONE) |=> (cnt == $past(cnt) - ONE));    // R2

endmodule

// File: rtl/ws_write_gate.sv
module ws_write_gate #(
    parameter int              NREG    = 4,
    parameter logic [NREG-1:0] RO_MASK = '0
) (
    input  logic [NREG-1:0] win_oh,
    input  logic            rd,
    input  logic            wr,
    output logic [NREG-1:0] dev_we
);

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_gate
            if (RO_MASK[gi]) begin : g_ro
                assign dev_we[gi] = 1'b0;
            end else begin : g_rw
                assign dev_we[gi] = wr & ~rd & win_oh[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/ws_ready_gen.sv
module ws_ready_gen #(
    parameter int                 NREG       = 4,
    parameter int                 CW         = 3,
    parameter logic [NREG*CW-1:0] WAIT_TABLE = {3'd5, 3'd2, 3'd1, 3'd0},
    parameter logic [NREG-1:0]    RO_MASK    = 4'b1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic [NREG-1:0] rgn_sel,
    input  logic            rd,
    input  logic            wr,
    output logic            ready,
    output logic            ro_err,
    output logic [NREG-1:0] dev_we
);

    import ws_pkg::*;

    ws_state_e       state, state_nx;
    logic [NREG-1:0] win_oh;
    logic            hit;
    logic [CW-1:0]   wait_n;
    logic            ro;
    logic [CW-1:0]   cnt;
    logic            last;
    logic            start_ok;
    logic            ro_wr;
    logic            load;

    ws_region_lookup #(
        .NREG(NREG), .CW(CW), .WAIT_TABLE(WAIT_TABLE), .RO_MASK(RO_MASK)
    ) u_lookup (
        .sel(rgn_sel), .win_oh(win_oh), .hit(hit), .wait_n(wait_n), .ro(ro)
    );

    ws_write_gate #(
        .NREG(NREG), .RO_MASK(RO_MASK)
    ) u_gate (
        .win_oh(win_oh), .rd(rd), .wr(wr), .dev_we(dev_we)
    );

    ws_countdown #(
        .CW(CW)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(wait_n),
        .dec(state == ST_STALL), .cnt(cnt), .last(last)
    );

    assign start_ok = cyc_start & (rd ^ wr) & hit;
    assign ro_wr    = wr & ro;
    assign load     = (state == ST_IDLE) & start_ok & ~ro_wr & (wait_n != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ok && ro_wr)                state_nx = ST_ERR;
                else if (start_ok && wait_n != '0)    state_nx = ST_STALL;
            end
            ST_STALL: begin
                if (last) state_nx = ST_IDLE;
            end
            ST_ERR:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready  = 1'b1;
        ro_err = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_STALL: ready  = 1'b0;
            ST_ERR:   ro_err = 1'b1;
            default:  ;
        endcase
    end

    AST_ZERO_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_ok && !ro_wr && wait_n == '0) |=> ready);      // R3

    AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready);                                                         // R2

    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && last) |=> ready);                                              // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !last) |=> !ready);                                            // R7

    AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_ok && ro_wr) |=> (ro_err && ready));           // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ro_err |=> !ro_err);                                                      // R8

endmodule

// File: tb/ws_ready_gen_test.sv
`timescale 1ns/1ps
module ws_ready_gen_test;

    localparam int NREG = 4;
    localparam int CW   = 3;
    localparam logic [NREG*CW-1:0] WT = {3'd5, 3'd2, 3'd1, 3'd0};
    localparam logic [NREG-1:0]    RO = 4'b1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cyc_start = 1'b0;
    logic [NREG-1:0] rgn_sel = '0;
    logic            rd = 1'b0;
    logic            wr = 1'b0;
    logic            ready;
    logic            ro_err;
    logic [NREG-1:0] dev_we;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ws_ready_gen #(.NREG(NREG), .CW(CW), .WAIT_TABLE(WT), .RO_MASK(RO)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rgn_sel(rgn_sel),
        .rd(rd), .wr(wr), .ready(ready), .ro_err(ro_err), .dev_we(dev_we)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one access; retrig >= 0 re-pulses cyc_start at that sample index
    task automatic access(input logic [NREG-1:0] s, input bit r, input bit w,
                          input int retrig, input string tag);
        int win = -1;
        int exp_n = 0;
        int exp_err = 0;
        int exp_we = 0;
        int lows = 0, first = -1, lastl = -1, errs = 0, err_at = -1;
        for (int i = NREG - 1; i >= 0; i--) if (s[i]) win = i;
        if (win >= 0 && (r ^ w)) begin
            if (w && RO[win]) exp_err = 1;
            else exp_n = int'(WT[win*CW +: CW]);
        end
        if (win >= 0 && w && !r && !RO[win]) exp_we = 1 << win;
        @(negedge clk);
        rgn_sel = s; rd = r; wr = w; cyc_start = 1'b1;
        #1;
        chk(int'(dev_we) == exp_we, {tag, " R9 dev_we"}, int'(dev_we), exp_we);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!ready) begin
                lows++;
                if (first < 0) first = k;
                lastl = k;
            end
            if (ro_err) begin
                errs++;
                if (err_at < 0) err_at = k;
            end
            cyc_start = (k == retrig);
        end
        cyc_start = 1'b0; rgn_sel = '0; rd = 1'b0; wr = 1'b0;
        chk(lows == exp_n, {tag, " R2 wait count"}, lows, exp_n);
        if (exp_n > 0)
            chk(first == 0 && lastl == exp_n - 1, {tag, " R2 wait window end"}, lastl, exp_n - 1);
        chk(errs == exp_err, {tag, " R8 err count"}, errs, exp_err);
        if (exp_err > 0) begin
            chk(err_at == 0, {tag, " R8 err timing"}, err_at, 0);
            chk(lows == 0, {tag, " R8 no wait"}, lows, 0);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", ready, 1);
        chk(ro_err == 1'b0, "R1 reset err", ro_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R3 R10: each region alone, read and write
        for (int i = 0; i < NREG; i++) begin
            access(NREG'(1 << i), 1'b1, 1'b0, -1, $sformatf("R4 rd region%0d", i));
            access(NREG'(1 << i), 1'b0, 1'b1, -1, $sformatf("R10 wr region%0d", i));
        end

        // R5 R6 R9 sweep of every select pattern and strobe mix
        for (int s = 0; s < (1 << NREG); s++) begin
            for (int m = 0; m < 4; m++) begin
                access(NREG'(s), m[0], m[1], -1, $sformatf("R5 R6 sel%0d mode%0d", s, m));
            end
        end

        // R7: restart attempts inside a stall on region 3 (5 waits)
        for (int k = 0; k < 5; k++) begin
            access(4'b1000, 1'b1, 1'b0, k, $sformatf("R7 retrig at %0d", k));
        end
        // R7: restart during the error pulse
        access(4'b1000, 1'b0, 1'b1, 0, "R7 retrig in err");

        // R1: reset in the middle of a stall
        @(negedge clk);
        rgn_sel = 4'b1000; rd = 1'b1; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk(ready == 1'b0, "R2 stall before reset", ready, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R1 mid-stall reset ready", ready, 1);
        rst_n = 1'b1; rgn_sel = '0; rd = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R1 after reset ready", ready, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule